// File: doc/BRIEF.md
# Variable Range Encoder and Validator

This unit turns a memory region request into the pair of register words that describe a variable memory-type range, and turns such a pair back into a region. An encode request gives a start page number, a length in 4 KiB pages and a memory-type code. The unit first checks the request: the length must be a power of two, the start must be a multiple of the length, and the type code must be one that is defined. When the legacy-model input is set, two extra rules apply. It then produces a base word and a mask word. A length of zero produces the pair that switches the range off.

A decode request gives a base word and a mask word. The unit returns the start page, the length and the type. When the mask word is not marked valid, it reports a free range. A mask whose high bits are missing is repaired before the length is derived, and a flag in the response says that a repair was made.

Each request travels on a valid/ready channel, and its response returns on a second valid/ready channel. The unit holds one response at a time. A request is accepted only when no response is waiting, or when the waiting response is consumed in the same cycle. While the consumer holds `rsp_ready` low, the response stays frozen. `req_legacy` is a plain control pin and is sampled when the request is accepted.

Top module: `vr_range_codec`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and its response is presented with `rsp_valid` high from the next edge. `req_ready` equals `!rsp_valid || rsp_ready`. A presented response is withdrawn after an edge where `rsp_ready` is high, unless a new request is accepted on that same edge.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and every response field keep their values.
- R3: A valid encode (`req_op`=0) returns base word = page×2^12 + type, with bits 11:8 zero. It returns mask word bits 39:12 = (2^28 − size) mod 2^28, bit 11 = 1 and bits 10:0 = 0. It also returns `rsp_err`=0, and page, size, type and fixed all zero.
- R4: An encode with size 0 returns both words as zero and `rsp_err`=0, whatever the other inputs are.
- R5: An encode with a size above 2^28, a size that is not a power of two, or a page that is not a multiple of the size returns `rsp_err`=1 with both words zero.
- R6: Only the type codes 0, 1, 4, 5 and 6 are accepted. Any other code with a non-zero size returns `rsp_err`=1 with both words zero.
- R7: With `req_legacy`=1 and a non-zero size, a page whose bits 9:0 are not all zero returns `rsp_err`=1.
- R8: With `req_legacy`=1 and type 1 or 6, a request is rejected unless page+size < 0x70000 or page > 0x7003F.
- R9: A decode (`req_op`=1) whose mask word bit 11 is 0 returns page, size, type, fixed and err all zero.
- R10: A decode of a valid mask returns type = base word bits 7:0 and page = base word bits 39:12. Both words in the response are zero and `rsp_err`=0.
- R11: For a valid mask, let m = mask word bits 39:12. If m ≠ 0, every bit above the highest set bit of m is forced to one. `rsp_fixed` is 1 exactly when this changes m. The size is 2^28 minus the repaired m, so m = 0 gives 2^28.
- R12: During and straight after reset, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 1 | 0 = encode, 1 = decode |
| req_page | input | 28 | Encode: start page number |
| req_size | input | 29 | Encode: length in pages (0 disables) |
| req_type | input | 8 | Encode: memory-type code |
| req_base_word | input | 40 | Decode: base register word |
| req_mask_word | input | 40 | Decode: mask register word |
| req_legacy | input | 1 | Enables the legacy-model rules |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_base_word | output | 40 | Encode result: base word |
| rsp_mask_word | output | 40 | Encode result: mask word |
| rsp_page | output | 28 | Decode result: start page |
| rsp_size | output | 29 | Decode result: length in pages |
| rsp_type | output | 8 | Decode result: memory type |
| rsp_err | output | 1 | Encode request rejected |
| rsp_fixed | output | 1 | Decode repaired the mask |

## Verification
The only state is the single response slot, so a fault there shows at the ports within one cycle. It appears as a response that fails to appear after an accept, a response that outlives its consuming edge, or a field that drifts while `rsp_ready` is low. Faults in the combinational checks show as a wrong `rsp_err` or a wrong word on the response of that very request. Requests placed on the edges of each rule (the top of the page space, the window bounds, masks with the top bit clear) make a one-off error in a comparison or a shift visible at once.

// File: rtl/vr_pkg.sv
package vr_pkg;
  localparam int TYPE_W = 8;
  typedef logic [TYPE_W-1:0] mtype_t;

  typedef enum logic {
    OP_ENC = 1'b0,
    OP_DEC = 1'b1
  } op_e;

  localparam mtype_t MT_UC = 8'd0;
  localparam mtype_t MT_WC = 8'd1;
  localparam mtype_t MT_WT = 8'd4;
  localparam mtype_t MT_WP = 8'd5;
  localparam mtype_t MT_WB = 8'd6;

  function automatic logic mtype_ok(input mtype_t t);
    return (t == MT_UC) || (t == MT_WC) || (t == MT_WT) ||
           (t == MT_WP) || (t == MT_WB);
  endfunction

  function automatic logic mtype_writable(input mtype_t t);
    return (t == MT_WC) || (t == MT_WB);
  endfunction
endpackage

// File: rtl/vr_align_chk.sv
// Natural-alignment test: strip the common run of (base bit 0, last bit 1)
// from the bottom and require the remaining upper parts to match.
module vr_align_chk #(
  parameter int PW = 28
) (
  input  logic [PW-1:0] base,
  input  logic [PW:0]   size,
  output logic          ok
);
  logic [PW:0] b_ext;
  logic [PW:0] last;
  logic [PW:0] run;     // run[i]: every bit below i is part of the stripped run
  logic [PW:0] bit_ok;

  assign b_ext  = {1'b0, base};
  assign last   = b_ext + size - {{PW{1'b0}}, 1'b1};
  assign run[0] = 1'b1;

  generate
    for (genvar i = 0; i <= PW; i++) begin : g_bit
      logic strip;
      assign strip     = run[i] & ~b_ext[i] & last[i];
      assign bit_ok[i] = strip | (b_ext[i] == last[i]);
      if (i < PW) begin : g_chain
        assign run[i+1] = strip;
      end
    end
  endgenerate

  assign ok = &bit_ok;
endmodule

// File: rtl/vr_encode.sv
module vr_encode
  import vr_pkg::*;
#(
  parameter int          PW       = 28,
  parameter int          OFS      = 12,
  parameter int          LEG_BITS = 10,
  parameter logic [PW-1:0] WIN_LO = 28'h0070000,
  parameter logic [PW-1:0] WIN_HI = 28'h007003F,
  localparam int         WW       = PW + OFS,
  localparam int         VB       = OFS - 1
) (
  input  logic [PW-1:0] page,
  input  logic [PW:0]   size,
  input  mtype_t        mtype,
  input  logic          legacy,
  output logic [WW-1:0] base_word,
  output logic [WW-1:0] mask_word,
  output logic          err
);
  logic          aligned;
  logic          is_zero;
  logic          too_big;
  logic          bad_type;
  logic          bad_leg_align;
  logic          bad_window;
  logic          fault;
  logic [PW:0]   end_pg;
  logic [PW-1:0] neg_size;

  vr_align_chk #(.PW(PW)) u_align (
    .base (page),
    .size (size),
    .ok   (aligned)
  );

  assign is_zero       = (size == '0);
  assign too_big       = size[PW] & (|size[PW-1:0]);
  assign bad_type      = !mtype_ok(mtype);
  assign bad_leg_align = legacy & (|page[LEG_BITS-1:0]);
  assign end_pg        = {1'b0, page} + size;
  assign bad_window    = legacy & mtype_writable(mtype) &
                         !((end_pg < {1'b0, WIN_LO}) || (page > WIN_HI));
  assign fault         = too_big | !aligned | bad_type | bad_leg_align | bad_window;
  assign neg_size      = ~size[PW-1:0] + {{(PW-1){1'b0}}, 1'b1};

  always_comb begin
    base_word = '0;
    mask_word = '0;
    err       = 1'b0;
    if (!is_zero) begin
      if (fault) begin
        err = 1'b1;
      end else begin
        base_word = {page, {(OFS-TYPE_W){1'b0}}, mtype};
        mask_word = {neg_size, 1'b1, {VB{1'b0}}};
      end
    end
  end

  always_comb begin
    if (!err && !is_zero) begin
      // R3
      enc_mask_sum_chk: assert ((mask_word[WW-1:OFS] + size[PW-1:0]) == '0);
      // R5
      enc_pow2_chk: assert (($countones(size) == 1) &&
                            (({1'b0, page} & (size - 1'b1)) == '0));
      // R7
      enc_leg_align_chk: assert (!legacy || (page % (1 << LEG_BITS)) == 0);
    end
  end
endmodule

// File: rtl/vr_decode.sv
module vr_decode
  import vr_pkg::*;
#(
  parameter int  PW  = 28,
  parameter int  OFS = 12,
  localparam int WW  = PW + OFS,
  localparam int VB  = OFS - 1
) (
  input  logic [WW-1:0] base_word,
  input  logic [WW-1:0] mask_word,
  output logic [PW-1:0] page,
  output logic [PW:0]   size,
  output mtype_t        mtype,
  output logic          fixed
);
  logic [PW-1:0] m;
  logic [PW:0]   any_up;   // any_up[i]: some bit of m at or above i is set
  logic [PW-1:0] repaired;
  logic          in_use;
  logic          unused_low;

  assign m          = mask_word[WW-1:OFS];
  assign in_use     = mask_word[VB];
  assign unused_low = ^{mask_word[VB-1:0], base_word[OFS-1:TYPE_W]};
  assign any_up[PW] = 1'b0;

  generate
    for (genvar i = PW - 1; i >= 0; i--) begin : g_up
      assign any_up[i] = any_up[i+1] | m[i];
    end
  endgenerate

  assign repaired = (m == '0) ? m : (m | ~any_up[PW-1:0]);

  always_comb begin
    page  = '0;
    size  = '0;
    mtype = '0;
    fixed = 1'b0;
    if (in_use) begin
      page  = base_word[WW-1:OFS];
      mtype = base_word[TYPE_W-1:0];
      fixed = (repaired != m);
      size  = {1'b1, {PW{1'b0}}} - {1'b0, repaired};
    end
  end

  always_comb begin
    if (in_use && m != '0) begin
      // R11
      dec_top_set_chk: assert (size <= {2'b01, {(PW-1){1'b0}}});
    end
    if (fixed) begin
      // R11
      dec_fix_cause_chk: assert (!m[PW-1]);
    end
  end
endmodule

// File: rtl/vr_range_codec.sv
module vr_range_codec
  import vr_pkg::*;
#(
  parameter int            PAGE_W   = 28,
  parameter int            OFS      = 12,
  parameter int            LEG_BITS = 10,
  parameter logic [27:0]   WIN_LO   = 28'h0070000,
  parameter logic [27:0]   WIN_HI   = 28'h007003F,
  localparam int           WW       = PAGE_W + OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [PAGE_W:0]   req_size,
  input  logic [7:0]        req_type,
  input  logic [WW-1:0]     req_base_word,
  input  logic [WW-1:0]     req_mask_word,
  input  logic              req_legacy,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WW-1:0]     rsp_base_word,
  output logic [WW-1:0]     rsp_mask_word,
  output logic [PAGE_W-1:0] rsp_page,
  output logic [PAGE_W:0]   rsp_size,
  output logic [7:0]        rsp_type,
  output logic              rsp_err,
  output logic              rsp_fixed
);
  op_e           op;
  logic          accept;
  logic [WW-1:0] enc_base, enc_mask;
  logic          enc_err;
  logic [PAGE_W-1:0] dec_page;
  logic [PAGE_W:0]   dec_size;
  mtype_t        dec_type;
  logic          dec_fixed;

  assign op        = op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  vr_encode #(
    .PW(PAGE_W), .OFS(OFS), .LEG_BITS(LEG_BITS),
    .WIN_LO(WIN_LO[PAGE_W-1:0]), .WIN_HI(WIN_HI[PAGE_W-1:0])
  ) u_enc (
    .page      (req_page),
    .size      (req_size),
    .mtype     (req_type),
    .legacy    (req_legacy),
    .base_word (enc_base),
    .mask_word (enc_mask),
    .err       (enc_err)
  );

  vr_decode #(.PW(PAGE_W), .OFS(OFS)) u_dec (
    .base_word (req_base_word),
    .mask_word (req_mask_word),
    .page      (dec_page),
    .size      (dec_size),
    .mtype     (dec_type),
    .fixed     (dec_fixed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_base_word <= '0;
      rsp_mask_word <= '0;
      rsp_page      <= '0;
      rsp_size      <= '0;
      rsp_type      <= '0;
      rsp_err       <= 1'b0;
      rsp_fixed     <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (op == OP_ENC) begin
        rsp_base_word <= enc_base;
        rsp_mask_word <= enc_mask;
        rsp_page      <= '0;
        rsp_size      <= '0;
        rsp_type      <= '0;
        rsp_err       <= enc_err;
        rsp_fixed     <= 1'b0;
      end else begin
        rsp_base_word <= '0;
        rsp_mask_word <= '0;
        rsp_page      <= dec_page;
        rsp_size      <= dec_size;
        rsp_type      <= dec_type;
        rsp_err       <= 1'b0;
        rsp_fixed     <= dec_fixed;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R1
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R1
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);

  // R2
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_base_word) &&
      $stable(rsp_mask_word) && $stable(rsp_page) && $stable(rsp_size) &&
      $stable(rsp_type) && $stable(rsp_err) && $stable(rsp_fixed));

  // R5
  err_words_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_base_word == '0 && rsp_mask_word == '0);

  // R10
  dec_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fixed |-> !rsp_err && rsp_mask_word == '0);
endmodule

// File: tb/test_vr_range_codec.sv
module test_vr_range_codec;
  localparam longint P28 = 64'h1000_0000;
  localparam longint M28 = 64'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [27:0] req_page = '0;
  logic [28:0] req_size = '0;
  logic [7:0]  req_type = '0;
  logic [39:0] req_base_word = '0;
  logic [39:0] req_mask_word = '0;
  logic        req_legacy = 1'b0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_err, rsp_fixed;
  logic [39:0] rsp_base_word, rsp_mask_word;
  logic [27:0] rsp_page;
  logic [28:0] rsp_size;
  logic [7:0]  rsp_type;

  int total = 0;
  int bad = 0;
  bit bp_mode = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vr_range_codec i_vr_range_codec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_page(req_page), .req_size(req_size),
    .req_type(req_type), .req_base_word(req_base_word),
    .req_mask_word(req_mask_word), .req_legacy(req_legacy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_base_word(rsp_base_word), .rsp_mask_word(rsp_mask_word),
    .rsp_page(rsp_page), .rsp_size(rsp_size), .rsp_type(rsp_type),
    .rsp_err(rsp_err), .rsp_fixed(rsp_fixed)
  );

  // reference model state
  bit     ev = 0;
  longint e_bw, e_mw, e_pg, e_sz, e_ty;
  bit     e_err, e_fix;
  string  tag_w, tag_p, tag_s;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_enc();
    longint pg, sz, t, lb, lt;
    bit     rej;
    pg = longint'(req_page); sz = longint'(req_size); t = longint'(req_type);
    e_pg = 0; e_sz = 0; e_ty = 0; e_fix = 0; e_err = 0; e_bw = 0; e_mw = 0;
    if (sz == 0) begin
      tag_w = "R4";
    end else begin
      rej = 0; tag_w = "R3";
      if (!(t == 0 || t == 1 || t == 4 || t == 5 || t == 6)) begin rej = 1; tag_w = "R6"; end
      if (sz > P28) begin
        rej = 1; tag_w = "R5";
      end else begin
        lb = pg; lt = pg + sz - 1;
        while (((lb & 1) == 0) && ((lt & 1) == 1)) begin lb = lb >> 1; lt = lt >> 1; end
        if (lb != lt) begin rej = 1; tag_w = "R5"; end
      end
      if (req_legacy && (pg % 1024) != 0) begin rej = 1; tag_w = "R7"; end
      if (req_legacy && (t == 1 || t == 6) && !((pg + sz) < 'h70000 || pg > 'h7003F)) begin
        rej = 1; tag_w = "R8";
      end
      if (rej) e_err = 1;
      else begin
        e_bw = (pg << 12) | t;
        e_mw = (((P28 - sz) & M28) << 12) | 'h800;
      end
    end
    tag_p = tag_w; tag_s = tag_w;
  endtask

  task automatic model_dec();
    longint bw, mw, m, mm;
    int hi;
    bw = longint'(req_base_word); mw = longint'(req_mask_word);
    e_bw = 0; e_mw = 0; e_err = 0;
    if (((mw >> 11) & 1) == 0) begin
      e_pg = 0; e_sz = 0; e_ty = 0; e_fix = 0;
      tag_w = "R9"; tag_p = "R9"; tag_s = "R9";
    end else begin
      e_pg = (bw >> 12) & M28;
      e_ty = bw & 255;
      m = (mw >> 12) & M28;
      mm = m;
      if (m != 0) begin
        hi = 27;
        while (((m >> hi) & 1) == 0) hi--;
        mm = m | (M28 & ~((longint'(1) << (hi + 1)) - 1));
      end
      e_fix = (mm != m);
      e_sz = P28 - mm;
      tag_w = "R10"; tag_p = "R10"; tag_s = "R11";
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) ev = 0;
    else if (req_valid && (!ev || rsp_ready)) begin
      ev = 1;
      if (req_op) model_dec(); else model_enc();
    end else if (rsp_ready) ev = 0;
  end

  // back-pressure pattern
  always @(negedge clk) rsp_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;

  // per-cycle comparison
  bit     pv_bp = 0;
  longint h_bw, h_mw, h_sz;
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(rsp_valid == ev, "R1", "rsp_valid", rsp_valid, ev);
      chk(req_ready == (!ev || rsp_ready), "R1", "req_ready", req_ready, !ev || rsp_ready);
      if (pv_bp) begin
        chk(rsp_valid && rsp_base_word == h_bw && rsp_mask_word == h_mw && rsp_size == h_sz,
            "R2", "held response", rsp_base_word, h_bw);
      end
      if (rsp_valid && ev) begin
        chk(rsp_base_word == e_bw, tag_w, "base_word", rsp_base_word, e_bw);
        chk(rsp_mask_word == e_mw, tag_w, "mask_word", rsp_mask_word, e_mw);
        chk(rsp_err == e_err, tag_w, "err", rsp_err, e_err);
        chk(rsp_page == e_pg, tag_p, "page", rsp_page, e_pg);
        chk(rsp_type == e_ty, tag_p, "type", rsp_type, e_ty);
        chk(rsp_size == e_sz, tag_s, "size", rsp_size, e_sz);
        chk(rsp_fixed == e_fix, tag_s, "fixed", rsp_fixed, e_fix);
      end
      pv_bp = rsp_valid && !rsp_ready;
      h_bw = rsp_base_word; h_mw = rsp_mask_word; h_sz = rsp_size;
    end
  end

  task automatic send(bit op, longint pg, longint sz, longint t, longint bw, longint mw, bit leg);
    @(negedge clk);
    req_valid = 1; req_op = op;
    req_page = pg[27:0]; req_size = sz[28:0]; req_type = t[7:0];
    req_base_word = bw[39:0]; req_mask_word = mw[39:0]; req_legacy = leg;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic enc(longint pg, longint sz, longint t, bit leg);
    send(0, pg, sz, t, 0, 0, leg);
  endtask

  task automatic dec(longint bw, longint mw);
    send(1, 0, 0, 0, bw, mw, 0);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rsp_valid == 0, "R12", "rsp_valid in reset", rsp_valid, 0);
    chk(req_ready == 1, "R12", "req_ready in reset", req_ready, 1);
    @(negedge clk); rst_n = 1;
    #1;
    chk(rsp_valid == 0 && req_ready == 1, "R12", "after reset", rsp_valid, 0);

    // R3 plain encodes
    enc('h100, 'h100, 6, 0);
    enc('h12345, 1, 0, 0);
    enc(0, P28, 4, 0);
    enc('h8000000, 'h8000000, 5, 0);
    // R4 disable
    enc('h123, 0, 9, 1);
    // R5 alignment faults
    enc('h100, 'h300, 6, 0);
    enc('h180, 'h100, 6, 0);
    enc(0, P28 + 1, 0, 0);
    // R6 type codes
    enc('h100, 'h100, 2, 0);
    enc('h100, 'h100, 3, 0);
    enc('h100, 'h100, 7, 0);
    enc('h100, 'h100, 'hFF, 0);
    // R7 legacy 4 MiB rule
    enc('h401, 1, 0, 1);
    enc('h400, 'h400, 0, 1);
    // R8 legacy window
    enc('h70000, 'h400, 6, 1);
    enc('h70000, 'h400, 0, 1);
    enc('h6FC00, 'h400, 1, 1);
    enc('h6FC00, 'h400, 1, 0);
    enc('h70400, 'h400, 1, 1);
    enc('h6F800, 'h400, 6, 1);
    // R9 free range, R10 and R11 decodes
    dec('h0_1234_5006, 'hFF_FFFF_F000);
    dec(('h100 << 12) | 6, (((P28 - 'h100) & M28) << 12) | 'h800);
    dec('h7_0000_0001, ('hFF << 12) | 'h800);
    dec('h0_0000_0004, 'h800);
    dec('hA_BCDE_F000, ('hFFFF0F0 << 12) | 'h800);
    dec('h0_0000_0005, ('h8000000 << 12) | 'h800);

    // mixed traffic under back-pressure
    bp_mode = 1;
    for (int n = 0; n < 400; n++) begin
      longint sz, pg, mw, bw;
      int k;
      k = $urandom % 29;
      sz = longint'(1) << k;
      if (($urandom % 4) == 0) sz = longint'($urandom % 'h2000);
      pg = longint'($urandom) & M28;
      if (($urandom % 2) == 0) pg = pg & ~(sz - 1) & M28;
      bw = (longint'($urandom) << 8) ^ longint'($urandom);
      mw = (longint'($urandom) << 8) ^ longint'($urandom);
      bw = bw & 64'hFF_FFFF_FFFF;
      mw = mw & 64'hFF_FFFF_FFFF;
      if ((n % 3) == 0) dec(bw, mw);
      else enc(pg, sz, longint'($urandom % 8), bit'($urandom % 2));
    end
    bp_mode = 0;
    repeat (6) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule